// File: doc/BRIEF.md
# SR-IOV Capability Register File

This block is the extended-capability register set of a PCI Express physical function that can expose virtual functions. It sits on the function's configuration access path and answers dword-aligned reads and writes, with byte enables, that fall inside its 64-byte window. Accesses outside the window are left for other logic. The block holds the control word, the requested VF count, the system page size and six VF base address registers. Each field takes only the bits its fixed write mask allows. The initial and total VF counts, first-VF offset, VF stride, VF device ID, supported page sizes and the size and type of every VF BAR are elaboration parameters.

The block watches the VF Enable bit. When a write that covers the control word's low byte sets VF Enable while no VFs are active, the block raises a one-cycle enable pulse and latches the requested count as the active count. When such a write clears VF Enable while VFs are active, the block raises a one-cycle disable pulse, zeroes the active count and forces the requested count back to zero. Downstream logic that builds or tears down the functions acts on these pulses.

Top module: `vfcap_regs`

## Requirements
- R1: After reset the control word reads 0, the requested VF count reads 0, the system page size reads 0x0001, the active count is 0 and neither pulse is high.
- R2: An in-window read returns the addressed register one cycle after the request with rd_valid high. Dword 0 reads {next pointer, 4'h1, 16'h0010}. Dword 3 reads {total, initial}. Dword 5 reads {stride, offset}. Dword 6 reads {device ID, 16'h0}. Dword 7 reads the supported page sizes. Dwords 1 and 15 read 0. Writes to these dwords change nothing.
- R3: In the control dword (offset 0x08), only bit 0 (VF Enable), bit 3 (VF memory enable) and bit 4 (ARI hierarchy) are writable. Every other bit reads 0.
- R4: The requested VF count (offset 0x10, bits 15:0) is fully writable. Bits 31:16 read 0. Each byte lane is written only when its byte enable is set.
- R5: The system page size (offset 0x20) is writable only in the bits set in the supported-page-size parameter. That parameter must include 0x0553.
- R6: A write with byte enable 0 set to the control dword, with data bit 0 high while the active count is 0, raises vf_en_pulse for exactly the next cycle. In that same cycle vf_count shows the requested count held before the write.
- R7: A write with byte enable 0 set to the control dword, with data bit 0 low while the active count is nonzero, raises vf_dis_pulse for exactly the next cycle. It sets vf_count to 0 and makes the requested count read 0.
- R8: Any other request leaves both pulses low and vf_count unchanged. This covers a control write without byte enable 0, VF Enable written to the state already in force, and every access to other registers.
- R9: A VF BAR dword (offsets 0x24 to 0x38) reads (stored & ~(size-1)) | type. With the default parameters the layout is: BAR0 is 64-bit prefetchable memory of 16 KB (type 0xC); BAR2 is 32-bit memory of 4 KB (type 0x0); BAR3 is I/O of 256 bytes (type 0x1); BAR4 is 32-bit memory of 1 MB (type 0x0); BAR5 is unimplemented and reads 0.
- R10: The dword after a 64-bit memory BAR is its upper half. It is fully writable and carries no type bits. The default BAR1 is such an upper half.
- R11: A request at an address below the capability base, or at or beyond base + 0x40, gives no rd_valid, raises no pulse and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Configuration request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Configuration byte address; bits 1:0 are ignored |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables for the write |
| rd_valid | output | 1 | Read data valid, one cycle after an in-window read |
| rd_data | output | 32 | Read data |
| vf_en_pulse | output | 1 | One-cycle request to create vf_count functions |
| vf_dis_pulse | output | 1 | One-cycle request to tear down all functions |
| vf_count | output | 16 | Active VF count latched at enable |

## Verification
Every result of this block is due in the cycle after the request edge. Read data and rd_valid, both pulses and the new vf_count all come from registers loaded on that single edge, and register writes show up on the very next read. The bench drives each request on a falling edge and lets one rising edge pass. On the next falling edge it compares rd_valid, rd_data, both pulses and vf_count against a model that was updated when the request was issued. A read that follows a write therefore checks that the write landed within one cycle.

// File: rtl/vfcap_pkg.sv
package vfcap_pkg;

   // dword indices inside the 64-byte capability window
   localparam logic [3:0] DW_HDR   = 4'd0;
   localparam logic [3:0] DW_CAPS  = 4'd1;
   localparam logic [3:0] DW_CTRL  = 4'd2;
   localparam logic [3:0] DW_VFCNT = 4'd3;
   localparam logic [3:0] DW_NUMVF = 4'd4;
   localparam logic [3:0] DW_ROUTE = 4'd5;
   localparam logic [3:0] DW_DEVID = 4'd6;
   localparam logic [3:0] DW_SUPPG = 4'd7;
   localparam logic [3:0] DW_SYSPG = 4'd8;
   localparam logic [3:0] DW_BAR0  = 4'd9;
   localparam logic [3:0] DW_MIGR  = 4'd15;

   localparam int NUM_BARS  = 6;
   localparam int WIN_BYTES = 64;

   localparam int CTL_VFE = 0;
   localparam int CTL_MSE = 3;
   localparam int CTL_ARI = 4;
   localparam logic [15:0] CTRL_WMASK = 16'((1 << CTL_VFE) | (1 << CTL_MSE) | (1 << CTL_ARI));

   localparam logic [15:0] CAP_ID     = 16'h0010;
   localparam logic [3:0]  CAP_VER    = 4'h1;
   localparam logic [15:0] SUP_PG_MIN = 16'h0553;

   typedef struct packed {
      logic        vld;
      logic        wr;
      logic [3:0]  dw;
      logic [31:0] wdata;
      logic [3:0]  be;
   } vfcap_req_t;

   // per-byte masked merge of write data into a stored value
   function automatic logic [31:0] be_merge(input logic [31:0] old_v,
                                            input logic [31:0] wd,
                                            input logic [3:0]  be,
                                            input logic [31:0] wmask);
      logic [31:0] res;
      res = old_v;
      for (int b = 0; b < 4; b++) begin
         if (be[b]) begin
            res[b*8 +: 8] = (old_v[b*8 +: 8] & ~wmask[b*8 +: 8]) |
                            (wd[b*8 +: 8] & wmask[b*8 +: 8]);
         end
      end
      return res;
   endfunction

endpackage

// File: rtl/vfcap_decode.sv
module vfcap_decode
   import vfcap_pkg::*;
#(
   parameter int                ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] CAP_BASE = 12'h160
) (
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   input  logic [3:0]        req_be,
   output vfcap_req_t        req
);

   localparam logic [ADDR_W:0] WIN_END = {1'b0, CAP_BASE} + (ADDR_W+1)'(WIN_BYTES);

   logic hit;

   always_comb begin
      hit       = req_valid && (req_addr >= CAP_BASE) && ({1'b0, req_addr} < WIN_END);
      req.vld   = hit;
      req.wr    = req_write;
      req.dw    = req_addr[5:2] - CAP_BASE[5:2];
      req.wdata = req_wdata;
      req.be    = req_be;
   end

endmodule

// File: rtl/vfcap_ctrl.sv
module vfcap_ctrl
   import vfcap_pkg::*;
#(
   parameter logic [15:0] SUP_PG = 16'h0553
) (
   input  logic        clk,
   input  logic        rst_n,
   input  vfcap_req_t  req,
   output logic [15:0] ctrl_q,
   output logic [15:0] numvf_q,
   output logic [15:0] syspg_q,
   output logic [15:0] act_cnt_q,
   output logic        en_pulse_q,
   output logic        dis_pulse_q
);

   logic        wr_ctrl, wr_num, wr_sys;
   logic [31:0] ctrl_nx, num_nx, sys_nx;
   logic        go_up, go_down;

   always_comb begin
      wr_ctrl = req.vld && req.wr && (req.dw == DW_CTRL);
      wr_num  = req.vld && req.wr && (req.dw == DW_NUMVF);
      wr_sys  = req.vld && req.wr && (req.dw == DW_SYSPG);
      ctrl_nx = be_merge({16'h0, ctrl_q},  req.wdata, req.be, {16'h0, CTRL_WMASK});
      num_nx  = be_merge({16'h0, numvf_q}, req.wdata, req.be, 32'h0000_FFFF);
      sys_nx  = be_merge({16'h0, syspg_q}, req.wdata, req.be, {16'h0, SUP_PG});
      go_up   = wr_ctrl && req.be[0] &&  req.wdata[CTL_VFE] && (act_cnt_q == 16'h0);
      go_down = wr_ctrl && req.be[0] && !req.wdata[CTL_VFE] && (act_cnt_q != 16'h0);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q      <= 16'h0;
         numvf_q     <= 16'h0;
         syspg_q     <= 16'h0001;
         act_cnt_q   <= 16'h0;
         en_pulse_q  <= 1'b0;
         dis_pulse_q <= 1'b0;
      end else begin
         en_pulse_q  <= go_up;
         dis_pulse_q <= go_down;
         if (wr_ctrl) ctrl_q  <= ctrl_nx[15:0];
         if (wr_sys)  syspg_q <= sys_nx[15:0];
         if (go_up) begin
            act_cnt_q <= numvf_q;
         end else if (go_down) begin
            act_cnt_q <= 16'h0;
            numvf_q   <= 16'h0;
         end
         if (wr_num) numvf_q <= num_nx[15:0];
      end
   end

endmodule

// File: rtl/vfcap_bar_bank.sv
module vfcap_bar_bank
   import vfcap_pkg::*;
#(
   parameter logic [NUM_BARS-1:0][3:0] BAR_TYPE = {4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 4'hC},
   parameter logic [NUM_BARS-1:0][4:0] BAR_LOG2 = {5'd0, 5'd20, 5'd8, 5'd12, 5'd0, 5'd14}
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  vfcap_req_t                 req,
   output logic [NUM_BARS-1:0][31:0]  bar_rd
);

   for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
      localparam bit IS_UPPER = (i > 0) && (BAR_LOG2[(i > 0) ? i-1 : 0] != 5'd0) &&
                                !BAR_TYPE[(i > 0) ? i-1 : 0][0] &&
                                (BAR_TYPE[(i > 0) ? i-1 : 0][2:1] == 2'b10);
      localparam bit IS_IMPL  = (BAR_LOG2[i] != 5'd0);
      localparam bit IS_IO    = BAR_TYPE[i][0];
      localparam bit IS_64    = IS_IMPL && !IS_IO && (BAR_TYPE[i][2:1] == 2'b10);
      localparam logic [31:0] SIZE_M1 = (32'd1 << BAR_LOG2[i]) - 32'd1;
      localparam logic [31:0] WMASK   = IS_UPPER ? 32'hFFFF_FFFF :
                                        IS_IMPL  ? ~SIZE_M1 : 32'h0;
      localparam logic [31:0] TYPE_RD = (IS_IMPL && !IS_UPPER) ? {28'h0, BAR_TYPE[i]} : 32'h0;

      if (IS_IMPL && IS_IO && (BAR_LOG2[i] < 5'd2)) begin : g_bad_io
         $error("I/O VF BAR %0d must span at least 4 bytes", i);
      end
      if (IS_IMPL && !IS_IO && (BAR_LOG2[i] < 5'd4)) begin : g_bad_mem
         $error("memory VF BAR %0d must span at least 16 bytes", i);
      end
      if (IS_64 && (i == NUM_BARS-1)) begin : g_bad_64
         $error("64-bit VF BAR cannot start in the last slot");
      end
      if (IS_UPPER && IS_IMPL) begin : g_bad_upper
         $error("VF BAR %0d is the upper half of a 64-bit BAR and must have size 0", i);
      end

      logic [31:0] val_q;
      logic        hit;
      assign hit = req.vld && req.wr && (req.dw == DW_BAR0 + 4'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            val_q <= 32'h0;
         end else if (hit) begin
            val_q <= be_merge(val_q, req.wdata, req.be, WMASK);
         end
      end

      assign bar_rd[i] = (val_q & WMASK) | TYPE_RD;
   end

endmodule

// File: rtl/vfcap_regs.sv
module vfcap_regs
   import vfcap_pkg::*;
#(
   parameter int                       ADDR_W    = 12,
   parameter logic [ADDR_W-1:0]        CAP_BASE  = 12'h160,
   parameter logic [11:0]              NEXT_CAP  = 12'h000,
   parameter logic [15:0]              INIT_VFS  = 16'd8,
   parameter logic [15:0]              TOTAL_VFS = 16'd8,
   parameter logic [15:0]              FIRST_OFS = 16'd128,
   parameter logic [15:0]              VF_STRIDE = 16'd1,
   parameter logic [15:0]              VF_DEVID  = 16'h10CA,
   parameter logic [15:0]              SUP_PG    = 16'h0553,
   parameter logic [NUM_BARS-1:0][3:0] BAR_TYPE  = {4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 4'hC},
   parameter logic [NUM_BARS-1:0][4:0] BAR_LOG2  = {5'd0, 5'd20, 5'd8, 5'd12, 5'd0, 5'd14}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [31:0]       req_wdata,
   input  logic [3:0]        req_be,
   output logic              rd_valid,
   output logic [31:0]       rd_data,
   output logic              vf_en_pulse,
   output logic              vf_dis_pulse,
   output logic [15:0]       vf_count
);

   if ((SUP_PG & SUP_PG_MIN) != SUP_PG_MIN) begin : g_bad_pg
      $error("supported page sizes must include the mandatory set");
   end
   if (INIT_VFS > TOTAL_VFS) begin : g_bad_cnt
      $error("initial VF count exceeds total VF count");
   end
   if (CAP_BASE[1:0] != 2'b00) begin : g_bad_base
      $error("capability base must be dword aligned");
   end
   if (ADDR_W < 7 || (int'(CAP_BASE) + WIN_BYTES) > (1 << ADDR_W)) begin : g_bad_win
      $error("capability window does not fit the address space");
   end

   vfcap_req_t                req;
   logic [15:0]               ctrl_q, numvf_q, syspg_q;
   logic [NUM_BARS-1:0][31:0] bar_rd;
   logic [31:0]               rd_mux;

   vfcap_decode #(.ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE)) u_dec (
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_be    (req_be),
      .req       (req)
   );

   vfcap_ctrl #(.SUP_PG(SUP_PG)) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .req         (req),
      .ctrl_q      (ctrl_q),
      .numvf_q     (numvf_q),
      .syspg_q     (syspg_q),
      .act_cnt_q   (vf_count),
      .en_pulse_q  (vf_en_pulse),
      .dis_pulse_q (vf_dis_pulse)
   );

   vfcap_bar_bank #(.BAR_TYPE(BAR_TYPE), .BAR_LOG2(BAR_LOG2)) u_bars (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req),
      .bar_rd (bar_rd)
   );

   always_comb begin
      rd_mux = 32'h0;
      case (req.dw)
         DW_HDR:   rd_mux = {NEXT_CAP, CAP_VER, CAP_ID};
         DW_CAPS:  rd_mux = 32'h0;
         DW_CTRL:  rd_mux = {16'h0, ctrl_q};
         DW_VFCNT: rd_mux = {TOTAL_VFS, INIT_VFS};
         DW_NUMVF: rd_mux = {16'h0, numvf_q};
         DW_ROUTE: rd_mux = {VF_STRIDE, FIRST_OFS};
         DW_DEVID: rd_mux = {VF_DEVID, 16'h0};
         DW_SUPPG: rd_mux = {16'h0, SUP_PG};
         DW_SYSPG: rd_mux = {16'h0, syspg_q};
         DW_MIGR:  rd_mux = 32'h0;
         default: begin
            for (int i = 0; i < NUM_BARS; i++) begin
               if (req.dw == DW_BAR0 + 4'(i)) rd_mux = bar_rd[i];
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= 32'h0;
      end else begin
         rd_valid <= req.vld && !req.wr;
         if (req.vld && !req.wr) rd_data <= rd_mux;
      end
   end

endmodule

// File: rtl/vfcap_regs_chk.sv
module vfcap_regs_chk #(
   parameter int                ADDR_W   = 12,
   parameter logic [ADDR_W-1:0] CAP_BASE = 12'h160
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_write,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rd_valid,
   input logic [31:0]       rd_data,
   input logic              vf_en_pulse,
   input logic              vf_dis_pulse,
   input logic [15:0]       vf_count
);

   localparam logic [ADDR_W-3:0] CTRL_DWA = CAP_BASE[ADDR_W-1:2] + (ADDR_W-2)'(2);

   logic in_win;
   assign in_win = (req_addr >= CAP_BASE) &&
                   ({1'b0, req_addr} < ({1'b0, CAP_BASE} + (ADDR_W+1)'(64)));

   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(req_valid && !req_write && in_win)); // R2

   AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(req_addr[ADDR_W-1:2]) == CTRL_DWA) |->
      (rd_data[31:5] == 27'h0 && rd_data[2:1] == 2'b00)); // R3

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(vf_en_pulse && vf_dis_pulse)); // R6

   AST_EN_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      vf_en_pulse |-> $past(vf_count) == 16'h0); // R6

   AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      vf_dis_pulse |-> (vf_count == 16'h0 && $past(vf_count) != 16'h0)); // R7

   AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!vf_en_pulse && !vf_dis_pulse) |-> $stable(vf_count)); // R8

   AST_OUTSIDE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      $past(req_valid && !in_win) |-> (!rd_valid && !vf_en_pulse && !vf_dis_pulse)); // R11

endmodule

bind vfcap_regs vfcap_regs_chk #(.ADDR_W(ADDR_W), .CAP_BASE(CAP_BASE)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_write    (req_write),
   .req_addr     (req_addr),
   .rd_valid     (rd_valid),
   .rd_data      (rd_data),
   .vf_en_pulse  (vf_en_pulse),
   .vf_dis_pulse (vf_dis_pulse),
   .vf_count     (vf_count)
);

// File: tb/sim_vfcap_regs.sv
module sim_vfcap_regs;

   localparam int          CLK_PERIOD = 10;
   localparam int          AW         = 12;
   localparam logic [11:0] BASE       = 12'h160;
   localparam logic [11:0] NEXTP      = 12'h000;
   localparam logic [15:0] INITV      = 16'd8;
   localparam logic [15:0] TOTV       = 16'd8;
   localparam logic [15:0] OFSV       = 16'd128;
   localparam logic [15:0] STRV       = 16'd1;
   localparam logic [15:0] DIDV       = 16'h10CA;
   localparam logic [15:0] SUPV       = 16'h0553;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [11:0] req_addr;
   logic [31:0] req_wdata;
   logic [3:0]  req_be;
   logic        rd_valid, vf_en_pulse, vf_dis_pulse;
   logic [31:0] rd_data;
   logic [15:0] vf_count;

   int n_tests = 0;
   int n_fail  = 0;

   logic [15:0] m_ctrl, m_num, m_sys, m_act;
   logic [31:0] m_bar [6];

   always #(CLK_PERIOD/2) clk = ~clk;

   vfcap_regs #(
      .ADDR_W(AW), .CAP_BASE(BASE), .NEXT_CAP(NEXTP), .INIT_VFS(INITV),
      .TOTAL_VFS(TOTV), .FIRST_OFS(OFSV), .VF_STRIDE(STRV), .VF_DEVID(DIDV),
      .SUP_PG(SUPV),
      .BAR_TYPE({4'h0, 4'h0, 4'h1, 4'h0, 4'h0, 4'hC}),
      .BAR_LOG2({5'd0, 5'd20, 5'd8, 5'd12, 5'd0, 5'd14})
   ) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .rd_valid(rd_valid), .rd_data(rd_data), .vf_en_pulse(vf_en_pulse),
      .vf_dis_pulse(vf_dis_pulse), .vf_count(vf_count)
   );

   function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] d,
                                         logic [3:0] be, logic [31:0] m);
      logic [31:0] r = o;
      for (int b = 0; b < 4; b++)
         if (be[b]) r[b*8 +: 8] = (o[b*8 +: 8] & ~m[b*8 +: 8]) | (d[b*8 +: 8] & m[b*8 +: 8]);
      return r;
   endfunction

   // R9, R10: default BAR layout as stated in the requirements
   function automatic logic [31:0] bar_mask(int i);
      case (i)
         0: return ~32'h0000_3FFF;
         1: return 32'hFFFF_FFFF;
         2: return ~32'h0000_0FFF;
         3: return ~32'h0000_00FF;
         4: return ~32'h000F_FFFF;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] bar_type(int i);
      case (i)
         0: return 32'hC;
         3: return 32'h1;
         default: return 32'h0;
      endcase
   endfunction

   function automatic logic [31:0] model_read(int idx);
      case (idx)
         0: return {NEXTP, 4'h1, 16'h0010};
         2: return {16'h0, m_ctrl};
         3: return {TOTV, INITV};
         4: return {16'h0, m_num};
         5: return {STRV, OFSV};
         6: return {DIDV, 16'h0};
         7: return {16'h0, SUPV};
         8: return {16'h0, m_sys};
         9, 10, 11, 12, 13, 14: return m_bar[idx-9] | bar_type(idx-9);
         default: return 32'h0;
      endcase
   endfunction

   function automatic string tag_of(int idx);
      case (idx)
         2: return "R3";
         4: return "R4";
         8: return "R5";
         10: return "R10";
         9, 11, 12, 13, 14: return "R9";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(bit ok, string r, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", r, act, exp);
      end
   endtask

   task automatic access(bit wr, logic [11:0] a, logic [31:0] d, logic [3:0] be);
      bit          inwin = (a >= BASE) && (int'(a) < int'(BASE) + 64);
      int          idx   = inwin ? (int'(a) - int'(BASE)) / 4 : -1;
      logic [31:0] exp_rd = inwin ? model_read(idx) : 32'h0;
      bit          exp_en = 1'b0, exp_dis = 1'b0;
      logic [31:0] t;
      if (wr && inwin) begin
         case (idx)
            2: begin
               t = merge({16'h0, m_ctrl}, d, be, 32'h19);
               m_ctrl = t[15:0];
               if (be[0]) begin
                  if (m_act != 0 && !d[0]) begin
                     exp_dis = 1'b1; m_act = 16'h0; m_num = 16'h0;
                  end else if (m_act == 0 && d[0]) begin
                     exp_en = 1'b1; m_act = m_num;
                  end
               end
            end
            4: begin t = merge({16'h0, m_num}, d, be, 32'hFFFF); m_num = t[15:0]; end
            8: begin t = merge({16'h0, m_sys}, d, be, {16'h0, SUPV}); m_sys = t[15:0]; end
            9, 10, 11, 12, 13, 14: m_bar[idx-9] = merge(m_bar[idx-9], d, be, bar_mask(idx-9));
            default: ;
         endcase
      end
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      chk(rd_valid == (!wr && inwin), inwin ? "R2" : "R11", 32'(rd_valid), 32'(!wr && inwin));
      if (!wr && inwin) chk(rd_data == exp_rd, tag_of(idx), rd_data, exp_rd);
      chk(vf_en_pulse == exp_en, inwin ? "R6" : "R11", 32'(vf_en_pulse), 32'(exp_en));
      chk(vf_dis_pulse == exp_dis, inwin ? "R7" : "R11", 32'(vf_dis_pulse), 32'(exp_dis));
      chk(vf_count == m_act, "R8", 32'(vf_count), 32'(m_act));
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      m_ctrl = 0; m_num = 0; m_sys = 16'h1; m_act = 0;
      for (int i = 0; i < 6; i++) m_bar[i] = 32'h0;
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0; req_be = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!vf_en_pulse && !vf_dis_pulse && !rd_valid, "R1", 32'({vf_en_pulse, vf_dis_pulse, rd_valid}), 32'h0);
      chk(vf_count == 16'h0, "R1", 32'(vf_count), 32'h0);
      access(1'b0, BASE + 12'h08, 0, 4'h0);
      access(1'b0, BASE + 12'h10, 0, 4'h0);
      access(1'b0, BASE + 12'h20, 0, 4'h0);
      for (int i = 0; i < 16; i++) access(1'b0, BASE + 12'(4*i), 0, 4'h0);
      // R3: all-ones into control without VF Enable
      access(1'b1, BASE + 12'h08, 32'hFFFF_FFFE, 4'hF);
      access(1'b0, BASE + 12'h08, 0, 4'h0);
      // R4: NumVFs byte lanes
      access(1'b1, BASE + 12'h10, 32'hAAAA_0305, 4'h1);
      access(1'b1, BASE + 12'h10, 32'hAAAA_0300, 4'h2);
      access(1'b0, BASE + 12'h10, 0, 4'h0);
      // R6: enable latches the count
      access(1'b1, BASE + 12'h08, 32'h1, 4'h1);
      // R8: repeat enable and upper-byte-only control write
      access(1'b1, BASE + 12'h08, 32'h1, 4'h1);
      access(1'b1, BASE + 12'h08, 32'h0, 4'h2);
      access(1'b1, BASE + 12'h10, 32'h0000_0009, 4'hF);
      // R7: disable clears count and NumVFs
      access(1'b1, BASE + 12'h08, 32'h0, 4'hF);
      access(1'b0, BASE + 12'h10, 0, 4'h0);
      // R6: enable with zero count
      access(1'b1, BASE + 12'h08, 32'h1, 4'h1);
      // R5: system page size mask
      access(1'b1, BASE + 12'h20, 32'hFFFF_FFFF, 4'hF);
      access(1'b0, BASE + 12'h20, 0, 4'h0);
      // R9, R10: BAR masks
      for (int i = 0; i < 6; i++) begin
         access(1'b1, BASE + 12'(36 + 4*i), 32'hFFFF_FFFF, 4'hF);
         access(1'b0, BASE + 12'(36 + 4*i), 0, 4'h0);
      end
      // R2: read-only dwords ignore writes
      access(1'b1, BASE + 12'h0C, 32'h1234_5678, 4'hF);
      access(1'b0, BASE + 12'h0C, 0, 4'h0);
      // R11: edges of the window
      access(1'b1, BASE - 12'h4, 32'hFFFF_FFFF, 4'hF);
      access(1'b1, BASE + 12'h40, 32'hFFFF_FFFF, 4'hF);
      access(1'b0, BASE - 12'h4, 0, 4'h0);
      access(1'b0, BASE + 12'h40, 0, 4'h0);
      for (int i = 0; i < 16; i++) access(1'b0, BASE + 12'(4*i), 0, 4'h0);
      // random mix
      for (int k = 0; k < 4000; k++) begin
         int          r   = int'($urandom % 100);
         int          sel = int'($urandom % 10);
         logic [11:0] a;
         if (r < 8) begin
            if ($urandom % 2) a = BASE - 12'(4 * (1 + $urandom % 16));
            else              a = BASE + 12'h40 + 12'(4 * ($urandom % 32));
         end else if (sel < 3) a = BASE + 12'h08;
         else if (sel < 5)     a = BASE + 12'h10;
         else                  a = BASE + 12'(4 * ($urandom % 16));
         a = a | 12'($urandom % 4);
         access(1'($urandom % 2), a, $urandom, 4'($urandom % 16));
      end
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule